// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block resolves control transfers for a small 8-bit-data, 16-bit-address processor core. For a conditional branch it picks one of four condition flags (negative, overflow, carry, zero) with a 3-bit selector. It tests that flag for the required polarity. It then produces either the branch destination or the sequential address. The destination is the address of the instruction that follows the two-byte branch, plus a sign-extended 8-bit displacement. The sum wraps modulo 2^16.

The block also accepts an unconditional absolute jump, which loads a 16-bit target with no condition test. The result is registered: a request presented on one clock edge appears at the outputs after that edge, together with a one-cycle valid pulse. For a taken branch, a page-crossing indicator reports when the destination's upper address byte differs from that of the sequential address. Cycle-accounting logic elsewhere can use that indicator. Fetching the displacement and generating the flags happen outside this block.

Top module: `br_unit`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the following edge leaves `out_valid`, `taken`, `page_cross` at 0 and `next_pc` at 16'h0000.
- R2: The selector encodes the tested flag in `cond_sel[2:1]` (00 = N, 01 = V, 10 = C, 11 = Z) and the required flag value in `cond_sel[0]` (0 = clear, 1 = set). A branch request is taken exactly when the selected flag equals `cond_sel[0]`.
- R3: For a taken branch, `next_pc` equals `seq_pc` plus `disp` read as a two's-complement value in -128..+127, modulo 2^16.
- R4: For a branch that is not taken, `next_pc` equals `seq_pc` and `taken` is 0.
- R5: `page_cross` is 1 only after a taken branch whose `next_pc[15:8]` differs from `seq_pc[15:8]`; it is 0 after every untaken branch and every jump.
- R6: A jump request sets `taken` to 1, `next_pc` to `jmp_tgt` and `page_cross` to 0, whatever the flags, the selector and `br_req` are. A jump takes priority over a simultaneous branch request.
- R7: Outputs reflect a request sampled at one rising edge right after that edge. `out_valid` is 1 in exactly the cycles following an edge that sampled `br_req` or `jmp_req` high.
- R8: After an edge that samples no request, `taken`, `next_pc` and `page_cross` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_req | input | 1 | Evaluate a conditional branch this cycle |
| jmp_req | input | 1 | Perform an absolute jump this cycle |
| cond_sel | input | 3 | Flag select [2:1] and required polarity [0] |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| seq_pc | input | 16 | Address of the instruction after the branch |
| disp | input | 8 | Signed branch displacement |
| jmp_tgt | input | 16 | Absolute jump destination |
| out_valid | output | 1 | Outputs carry a fresh result |
| taken | output | 1 | Control transfer taken |
| next_pc | output | 16 | Resolved next program counter |
| page_cross | output | 1 | Taken branch left the 256-byte page |

## Verification
The only state in the block is the output register, so any fault in it shows at the ports one cycle after the request that should have loaded it. A wrong flag mapping or polarity shows as a `taken` mismatch, and a wrong sign extension shows as a `next_pc` error, in the first cycle after any branch whose displacement has bit 7 set. A register that fails to hold shows as a change after an idle cycle. The reference model compares all four outputs every cycle, so each such fault is seen at the earliest cycle it can appear. The model sweeps every selector against every flag pattern, with displacements of -128, -1, 0 and +127 around page and address-space edges.

// File: rtl/br_pkg.sv
// Package br_pkg
// Shared encodings for the branch unit: which flag a selector picks.
// Assumes the flag field sits in bits [2:1] of the condition selector.
package br_pkg;

    typedef enum logic [1:0] {
        FLG_NEG = 2'b00,
        FLG_OVF = 2'b01,
        FLG_CRY = 2'b10,
        FLG_ZER = 2'b11
    } flag_sel_e;

    typedef struct packed {
        logic n;
        logic v;
        logic c;
        logic z;
    } cpu_flags_t;

endpackage

// File: rtl/br_cond_eval.sv
// Module br_cond_eval
// Decides whether a conditional branch holds: picks one flag by the
// selector's upper field and compares it with the selector's low bit.
// Assumes a purely combinational use; no state.
module br_cond_eval
    import br_pkg::*;
(
    input  logic [2:0]  cond_sel,
    input  cpu_flags_t  flags,
    output logic        cond_met
);

    flag_sel_e which;
    logic      picked;

    // Purpose: decode the flag field and pick the tested flag.
    always_comb begin
        which = flag_sel_e'(cond_sel[2:1]);
        unique case (which)
            FLG_NEG: picked = flags.n;
            FLG_OVF: picked = flags.v;
            FLG_CRY: picked = flags.c;
            FLG_ZER: picked = flags.z;
            default: picked = 1'b0;
        endcase
    end

    // Purpose: compare the picked flag against the required polarity.
    always_comb begin
        cond_met = (picked == cond_sel[0]);
    end

endmodule

// File: rtl/br_target_calc.sv
// Module br_target_calc
// Forms the relative branch destination: sign-extends the displacement
// to the PC width and adds it to the sequential address, wrapping.
// Also flags a change of the address bits above the page offset.
// Assumes DISP_W < PC_W and PAGE_W < PC_W.
module br_target_calc #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic [PC_W-1:0]   seq_pc,
    input  logic [DISP_W-1:0] disp,
    output logic [PC_W-1:0]   rel_tgt,
    output logic              tgt_crosses
);

    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;

    // Purpose: sign-extend the displacement and add it modulo 2^PC_W.
    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        rel_tgt  = seq_pc + disp_ext;
    end

    // Purpose: detect that the destination lies in another page.
    always_comb begin
        tgt_crosses = (rel_tgt[PC_W-1:PAGE_W] != seq_pc[PC_W-1:PAGE_W]);
    end

endmodule

// File: rtl/br_unit.sv
// Module br_unit (top)
// Resolves a conditional relative branch or an absolute jump into a
// registered next-PC, taken flag and page-crossing flag, with a
// one-cycle valid pulse. Jumps win over branches. Outputs hold when
// no request is sampled. Synchronous active-low reset.
// Assumes requests are one-cycle strobes from the sequencer.
module br_unit
    import br_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_req,
    input  logic              jmp_req,
    input  logic [2:0]        cond_sel,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [PC_W-1:0]   seq_pc,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   jmp_tgt,
    output logic              out_valid,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic              page_cross
);

    cpu_flags_t      flags;
    logic            cond_met;
    logic [PC_W-1:0] rel_tgt;
    logic            tgt_crosses;
    logic            taken_d;
    logic [PC_W-1:0] next_pc_d;
    logic            cross_d;
    logic            any_req;

    // Purpose: gather the flag inputs into one struct.
    always_comb begin
        flags = '{n: flag_n, v: flag_v, c: flag_c, z: flag_z};
    end

    br_cond_eval u_cond (
        .cond_sel (cond_sel),
        .flags    (flags),
        .cond_met (cond_met)
    );

    br_target_calc #(
        .PC_W   (PC_W),
        .DISP_W (DISP_W),
        .PAGE_W (PAGE_W)
    ) u_tgt (
        .seq_pc      (seq_pc),
        .disp        (disp),
        .rel_tgt     (rel_tgt),
        .tgt_crosses (tgt_crosses)
    );

    // Purpose: choose the next-cycle result, giving jumps priority.
    always_comb begin
        any_req = br_req | jmp_req;
        if (jmp_req) begin
            taken_d   = 1'b1;
            next_pc_d = jmp_tgt;
            cross_d   = 1'b0;
        end else if (cond_met) begin
            taken_d   = 1'b1;
            next_pc_d = rel_tgt;
            cross_d   = tgt_crosses;
        end else begin
            taken_d   = 1'b0;
            next_pc_d = seq_pc;
            cross_d   = 1'b0;
        end
    end

    // Purpose: register the result on a request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            taken      <= 1'b0;
            next_pc    <= '0;
            page_cross <= 1'b0;
        end else begin
            out_valid <= any_req;
            if (any_req) begin
                taken      <= taken_d;
                next_pc    <= next_pc_d;
                page_cross <= cross_d;
            end
        end
    end

endmodule

// File: rtl/br_unit_chk.sv
// Module br_unit_chk
// Temporal checks on the branch unit's ports, attached by bind.
// Assumes the same parameters as the bound instance.
module br_unit_chk #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_req,
    input logic              jmp_req,
    input logic [PC_W-1:0]   seq_pc,
    input logic [DISP_W-1:0] disp,
    input logic [PC_W-1:0]   jmp_tgt,
    input logic              out_valid,
    input logic              taken,
    input logic [PC_W-1:0]   next_pc,
    input logic              page_cross
);

    localparam int EXT_W = PC_W - DISP_W;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req || jmp_req) |=> out_valid); // R7

    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_req || jmp_req) |=> !out_valid); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_req || jmp_req) |=> ($stable(taken) && $stable(next_pc) && $stable(page_cross))); // R8

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_req |=> (taken && !page_cross && next_pc == $past(jmp_tgt))); // R6

    AST_UNTAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !jmp_req) |=> (taken || next_pc == $past(seq_pc))); // R4

    AST_TAKEN_REL: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !jmp_req) |=> (!taken ||
            next_pc == $past(seq_pc + {{EXT_W{disp[DISP_W-1]}}, disp}))); // R3

    AST_CROSS_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross |-> taken); // R5

    AST_CROSS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !jmp_req) |=> (page_cross ==
            (taken && next_pc[PC_W-1:PAGE_W] != $past(seq_pc[PC_W-1:PAGE_W])))); // R5

endmodule

bind br_unit br_unit_chk #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W),
    .PAGE_W (PAGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_req     (br_req),
    .jmp_req    (jmp_req),
    .seq_pc     (seq_pc),
    .disp       (disp),
    .jmp_tgt    (jmp_tgt),
    .out_valid  (out_valid),
    .taken      (taken),
    .next_pc    (next_pc),
    .page_cross (page_cross)
);

// File: tb/tb_br_unit.sv
// Bench for br_unit: behavioural reference model updated on every rising
// edge, outputs compared on every falling edge.
module tb_br_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_req = 1'b0;
    logic        jmp_req = 1'b0;
    logic [2:0]  cond_sel = 3'd0;
    logic        flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
    logic [15:0] seq_pc = 16'h0;
    logic [7:0]  disp = 8'h0;
    logic [15:0] jmp_tgt = 16'h0;
    logic        out_valid, taken, page_cross;
    logic [15:0] next_pc;

    int n_checks = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // reference state
    bit    e_valid = 0, e_taken = 0, e_cross = 0;
    int    e_pc = 0;
    string e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    br_unit dut (
        .clk(clk), .rst_n(rst_n), .br_req(br_req), .jmp_req(jmp_req),
        .cond_sel(cond_sel), .flag_n(flag_n), .flag_v(flag_v),
        .flag_z(flag_z), .flag_c(flag_c), .seq_pc(seq_pc), .disp(disp),
        .jmp_tgt(jmp_tgt), .out_valid(out_valid), .taken(taken),
        .next_pc(next_pc), .page_cross(page_cross)
    );

    // Reference model: behaviour from the requirements, in integers.
    always @(posedge clk) begin
        int  fl;
        int  d;
        int  tgt;
        bit  hit;
        if (!rst_n) begin
            e_valid <= 0; e_taken <= 0; e_cross <= 0; e_pc <= 0; e_tag <= "R1";
        end else begin
            e_valid <= br_req || jmp_req;
            if (jmp_req) begin
                e_taken <= 1; e_pc <= int'(jmp_tgt); e_cross <= 0; e_tag <= "R6";
            end else if (br_req) begin
                // R2: [2:1] 00=N 01=V 10=C 11=Z, [0] = required value
                case (int'(cond_sel) / 2)
                    0: fl = int'(flag_n);
                    1: fl = int'(flag_v);
                    2: fl = int'(flag_c);
                    default: fl = int'(flag_z);
                endcase
                hit = (fl == int'(cond_sel) % 2);
                d   = (disp >= 8'd128) ? int'(disp) - 256 : int'(disp);
                tgt = (int'(seq_pc) + d + 65536) % 65536;
                e_taken <= hit;
                e_pc    <= hit ? tgt : int'(seq_pc);
                e_cross <= hit && ((tgt / 256) != (int'(seq_pc) / 256));
                e_tag   <= hit ? "R3" : "R4";
            end else begin
                e_tag <= "R8";
            end
        end
    end

    // Comparison on every falling edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            n_checks++;
            if (out_valid !== e_valid) begin
                n_fail++;
                $display("FAIL R7 (%s) out_valid act=%0b exp=%0b at %0t", e_tag, out_valid, e_valid, $time);
            end
            if (taken !== e_taken) begin
                n_fail++;
                $display("FAIL R2 (%s) taken act=%0b exp=%0b at %0t", e_tag, taken, e_taken, $time);
            end
            if (int'(next_pc) != e_pc || $isunknown(next_pc)) begin
                n_fail++;
                $display("FAIL %s next_pc act=%h exp=%h at %0t", e_tag, next_pc, e_pc[15:0], $time);
            end
            if (page_cross !== e_cross) begin
                n_fail++;
                $display("FAIL R5 (%s) page_cross act=%0b exp=%0b at %0t", e_tag, page_cross, e_cross, $time);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        br_req = 0; jmp_req = 0;
    endtask

    task automatic do_branch(input logic [2:0] cs, input logic [3:0] fl,
                             input logic [15:0] pc, input logic [7:0] d);
        @(negedge clk);
        br_req = 1; jmp_req = 0; cond_sel = cs;
        {flag_n, flag_v, flag_c, flag_z} = fl;
        seq_pc = pc; disp = d;
    endtask

    task automatic do_jump(input logic [15:0] t, input logic also_br);
        @(negedge clk);
        jmp_req = 1; br_req = also_br; jmp_tgt = t;
        seq_pc = ~t; disp = 8'h80; cond_sel = 3'd1; {flag_n, flag_v, flag_c, flag_z} = 4'hF;
    endtask

    function automatic logic [15:0] pc_pick(input int i);
        case (i)
            0: return 16'h12FE;
            1: return 16'h1280;
            2: return 16'h0005;
            3: return 16'hFFF0;
            default: return 16'h1200;
        endcase
    endfunction

    function automatic logic [7:0] disp_pick(input int i);
        case (i)
            0: return 8'h80;
            1: return 8'hFF;
            2: return 8'h00;
            default: return 8'h7F;
        endcase
    endfunction

    initial begin
        // R1: reset state observed while reset is held
        repeat (3) @(posedge clk);
        chk_en = 1'b1;
        repeat (2) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R4 R5: full sweep of selectors, flags, displacements, pages
        for (int p = 0; p < 5; p++) begin
            for (int cs = 0; cs < 8; cs++) begin
                for (int f = 0; f < 16; f++) begin
                    for (int k = 0; k < 4; k++) begin
                        do_branch(3'(cs), 4'(f), pc_pick(p), disp_pick(k));
                    end
                end
                // R8: outputs hold across idle cycles
                idle();
                idle();
            end
        end
        // R6: jumps, alone and against a simultaneous branch
        do_jump(16'hABCD, 1'b0);
        idle();
        do_jump(16'h0000, 1'b1);
        do_jump(16'hFFFF, 1'b1);
        do_branch(3'd0, 4'h0, 16'h00FF, 8'h01);
        idle();
        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle();
        idle();
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule